// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the timing enables for a serial transceiver. It picks one of three clock sources and divides it by a 16-bit integer divisor. In asynchronous operation it can also add a fraction of the divisor in eighths. The sources are the system clock itself, the system clock divided by a fixed prescaler, and an external clock pin. The result is a sampling enable. In asynchronous operation an oversampling divider then turns this enable into a bit-rate tick, taking every 16th or every 8th sampling enable.

In synchronous operation the divided clock becomes the bit clock directly. The block also drives a serial clock pin from it. If the external clock is selected in synchronous operation, each rising edge of that pin, once synchronised, gives one tick and no division takes place. The receiver and transmitter attach to the two enables. All outputs are single-cycle enables in the system clock domain, except the pin output.

The divider is a state machine with three states:
- `DIV_IDLE` holds while the divisor is zero. It moves to `DIV_COUNT` (transition *start*) as soon as the divisor is non-zero.
- `DIV_COUNT` counts source enables. At the last count it either:
  - emits a pulse and stays in `DIV_COUNT` (transition *reload*),
  - moves to `DIV_STRETCH` when the fractional accumulator overflows (transition *stretch*), or
  - returns to `DIV_IDLE` when the new divisor is zero (transition *stop*).
- `DIV_STRETCH` waits one extra source enable, then reloads (transition *finish*).
- A change of mode or source forces every state to `DIV_IDLE` (transition *restart*).

Top module: `frac_baud_gen`

## Requirements
- R1: The source select `src_sel_i` chooses the source. Code 0 gives an enable on every system clock. Code 1 gives one enable every PRESC system clocks (PRESC is 8 by default). Code 2 is reserved and produces no enables. Code 3 gives one enable per rising edge of `ext_clk_i`, after a two-stage synchroniser.
- R2: In asynchronous mode (`sync_mode_i`=0) with `frac_i`=0, `samp_en_o` pulses once every `div_i` source enables.
- R3: In asynchronous mode with `frac_i`≠0, each sampling period lasts either `div_i` or `div_i`+1 source enables. Any 8 consecutive periods total exactly 8·`div_i`+`frac_i` source enables.
- R4: In asynchronous mode, `baud_tick_o` pulses together with every 16th `samp_en_o` when `os8_i`=0, and with every 8th `samp_en_o` when `os8_i`=1.
- R5: In synchronous mode with an internal source, `samp_en_o` and `baud_tick_o` pulse together once every `div_i` source enables. `frac_i` and `os8_i` have no effect.
- R6: A `div_i` of 0 stops all pulses. A new `div_i` or `frac_i` value takes effect only when the current period ends.
- R7: In synchronous mode with code 3, each rising edge of `ext_clk_i` gives one `samp_en_o` and `baud_tick_o` pulse, even when `div_i` is 0. `clk_pin_o` follows the synchronised level of `ext_clk_i`.
- R8: In synchronous mode with code 0 and `div_i`≥2, `clk_pin_o` is high for exactly half of each period, to half-cycle resolution. This holds for odd `div_i` as well.
- R9: In synchronous mode with code 1, `clk_pin_o` is high for floor(`div_i`/2) source periods of each period. In asynchronous mode `clk_pin_o` stays low.
- R10: A change of `sync_mode_i` or `src_sel_i` restarts the divider and flushes any pending pulse. With code 0, the first `samp_en_o` after the change comes `div_i`+2 clock cycles after the change is applied.
- R11: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Clock source select code |
| div_i | input | 16 | Integer divisor |
| frac_i | input | 3 | Fractional addend in eighths |
| os8_i | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| sync_mode_i | input | 1 | 1 selects synchronous mode |
| ext_clk_i | input | 1 | External clock pin, asynchronous to `clk_i` |
| samp_en_o | output | 1 | Sampling clock enable |
| baud_tick_o | output | 1 | Bit-rate tick |
| clk_pin_o | output | 1 | Serial clock pin output for synchronous mode |

## Verification
Some properties are checked on every cycle:
- The divider count stays below the latched divisor.
- The stretch state is entered only with a non-zero fraction, and it always ends in exactly one pulse.
- A restart leaves the divider idle and silent.
- The prescaler and edge-detector enables never occur on two consecutive cycles.
- A bit tick never appears without a sampling enable.
- The pin stays low in asynchronous mode.

Other behaviour can only be shown by the bench scenarios: the period lengths, the eight-period fractional totals, the oversampling ratio, the half-cycle pin duty for odd divisors, the timing of a divisor change at reload, and the exact latency after a mode switch. These properties span many cycles and depend on how the stimulus is configured.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    typedef enum logic [1:0] {
        SRC_CORE  = 2'd0,
        SRC_PRESC = 2'd1,
        SRC_RSVD  = 2'd2,
        SRC_EXT   = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        DIV_IDLE    = 2'd0,
        DIV_COUNT   = 2'd1,
        DIV_STRETCH = 2'd2
    } div_state_e;

endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel
    import frac_baud_pkg::*;
#(
    parameter int unsigned PRESC = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    input  logic       ext_clk_i,
    output logic       src_en_o,
    output logic       ext_lvl_o,
    output logic       ext_rise_o
);

    localparam int unsigned PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);

    logic [PW-1:0] pcnt_q;
    logic          presc_en;
    logic          s1_q, s2_q, s3_q, rise_q;

    // fixed prescaler on the system clock
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pcnt_q <= '0;
        end else if (pcnt_q == PLAST) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    assign presc_en = (pcnt_q == PLAST);

    // external clock: two-stage synchroniser plus edge detector
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            s3_q   <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            s1_q   <= ext_clk_i;
            s2_q   <= s1_q;
            s3_q   <= s2_q;
            rise_q <= s2_q & ~s3_q;
        end
    end

    always_comb begin
        unique case (src_sel_e'(sel_i))
            SRC_CORE:  src_en_o = 1'b1;
            SRC_PRESC: src_en_o = presc_en;
            SRC_EXT:   src_en_o = rise_q;
            default:   src_en_o = 1'b0;
        endcase
    end

    assign ext_lvl_o  = s2_q;
    assign ext_rise_o = rise_q;

    assert_presc_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        presc_en |=> !presc_en);

    assert_ext_rise_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_q |=> !rise_q);

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div
    import frac_baud_pkg::*;
#(
    parameter int unsigned CD_W = 16,
    parameter int unsigned FP_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            restart_i,
    input  logic            src_en_i,
    input  logic [CD_W-1:0] cd_i,
    input  logic [FP_W-1:0] fp_i,
    output logic            pulse_o,
    output logic            running_o,
    output logic [CD_W-1:0] cnt_o,
    output logic [CD_W-1:0] cd_o
);

    localparam logic [CD_W-1:0] CD_ONE = CD_W'(1);

    div_state_e      state_q, state_d;
    logic [CD_W-1:0] cnt_q, cnt_d, cd_q, cd_d;
    logic [FP_W-1:0] fp_q, fp_d, acc_q, acc_d;
    logic [FP_W:0]   acc_sum;
    logic            pulse_q, pulse_d;

    assign acc_sum = {1'b0, acc_q} + {1'b0, fp_q};

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cd_d    = cd_q;
        fp_d    = fp_q;
        acc_d   = acc_q;
        pulse_d = 1'b0;
        if (restart_i) begin
            state_d = DIV_IDLE;
            cnt_d   = '0;
            acc_d   = '0;
        end else begin
            unique case (state_q)
                DIV_IDLE: begin
                    if (cd_i != '0) begin
                        state_d = DIV_COUNT;
                        cd_d    = cd_i;
                        fp_d    = fp_i;
                        cnt_d   = '0;
                        acc_d   = '0;
                    end
                end
                DIV_COUNT: begin
                    if (src_en_i) begin
                        if (cnt_q == cd_q - CD_ONE) begin
                            acc_d = acc_sum[FP_W-1:0];
                            if (acc_sum[FP_W]) begin
                                state_d = DIV_STRETCH;
                            end else begin
                                pulse_d = 1'b1;
                                cnt_d   = '0;
                                cd_d    = cd_i;
                                fp_d    = fp_i;
                                state_d = (cd_i == '0) ? DIV_IDLE : DIV_COUNT;
                            end
                        end else begin
                            cnt_d = cnt_q + CD_ONE;
                        end
                    end
                end
                DIV_STRETCH: begin
                    if (src_en_i) begin
                        pulse_d = 1'b1;
                        cnt_d   = '0;
                        cd_d    = cd_i;
                        fp_d    = fp_i;
                        state_d = (cd_i == '0) ? DIV_IDLE : DIV_COUNT;
                    end
                end
                default: state_d = DIV_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= DIV_IDLE;
            cnt_q   <= '0;
            cd_q    <= '0;
            fp_q    <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cd_q    <= cd_d;
            fp_q    <= fp_d;
            acc_q   <= acc_d;
        end
    end

    // output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o   = pulse_q;
    assign running_o = (state_q == DIV_COUNT);
    assign cnt_o     = cnt_q;
    assign cd_o      = cd_q;

    assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != DIV_IDLE) |-> (cnt_q < cd_q));

    assert_count_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != DIV_IDLE) |-> (cd_q != '0));

    assert_stretch_needs_frac_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == DIV_STRETCH) |-> (fp_q != '0));

    assert_stretch_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == DIV_STRETCH && src_en_i && !restart_i) |=> pulse_q);

    assert_restart_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (state_q == DIV_IDLE && !pulse_q));

endmodule

// File: rtl/baud_out_stage.sv
module baud_out_stage
    import frac_baud_pkg::*;
#(
    parameter int unsigned CD_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            restart_i,
    input  logic            sync_i,
    input  logic [1:0]      sel_i,
    input  logic            os8_i,
    input  logic            div_pulse_i,
    input  logic            running_i,
    input  logic [CD_W-1:0] cnt_i,
    input  logic [CD_W-1:0] cd_i,
    input  logic            ext_rise_i,
    input  logic            ext_lvl_i,
    output logic            samp_en_o,
    output logic            baud_tick_o,
    output logic            clk_pin_o
);

    localparam int unsigned OS_W = 4;

    logic [OS_W-1:0] os_cnt_q, os_last;
    logic            ext_direct, internal_src, os_wrap;
    logic            hi_p_q, hi_n_q, half_en;

    assign ext_direct   = sync_i && (sel_i == SRC_EXT);
    assign internal_src = (sel_i == SRC_CORE) || (sel_i == SRC_PRESC);
    assign os_last      = os8_i ? OS_W'(7) : OS_W'(15);
    assign os_wrap      = (os_cnt_q >= os_last);

    // oversampling divider (asynchronous mode only)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            os_cnt_q <= '0;
        end else if (restart_i) begin
            os_cnt_q <= '0;
        end else if (!sync_i && div_pulse_i) begin
            os_cnt_q <= os_wrap ? '0 : os_cnt_q + 1'b1;
        end
    end

    // pin high phase on the rising edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_p_q <= 1'b0;
        end else begin
            hi_p_q <= sync_i && internal_src && running_i && !restart_i
                      && (cnt_i < (cd_i >> 1));
        end
    end

    // half-cycle extension captured on the falling edge
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_n_q <= 1'b0;
        end else begin
            hi_n_q <= hi_p_q;
        end
    end

    assign half_en = (sel_i == SRC_CORE) && cd_i[0];

    always_comb begin
        if (ext_direct) begin
            samp_en_o   = ext_rise_i;
            baud_tick_o = ext_rise_i;
            clk_pin_o   = ext_lvl_i;
        end else if (sync_i) begin
            samp_en_o   = div_pulse_i;
            baud_tick_o = div_pulse_i;
            clk_pin_o   = hi_p_q | (half_en & hi_n_q);
        end else begin
            samp_en_o   = div_pulse_i;
            baud_tick_o = div_pulse_i && os_wrap;
            clk_pin_o   = hi_p_q | (half_en & hi_n_q);
        end
    end

    assert_tick_needs_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        baud_tick_o |-> samp_en_o);

    assert_pin_low_async_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_i && !$past(sync_i) && !$past(sync_i, 2)) |-> !clk_pin_o);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int unsigned CD_W  = 16,
    parameter int unsigned FP_W  = 3,
    parameter int unsigned PRESC = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [1:0]      src_sel_i,
    input  logic [CD_W-1:0] div_i,
    input  logic [FP_W-1:0] frac_i,
    input  logic            os8_i,
    input  logic            sync_mode_i,
    input  logic            ext_clk_i,
    output logic            samp_en_o,
    output logic            baud_tick_o,
    output logic            clk_pin_o
);

    logic            sync_q;
    logic [1:0]      sel_q;
    logic            restart;
    logic            src_en, ext_lvl, ext_rise;
    logic            div_pulse, running;
    logic [CD_W-1:0] cnt, cd_live;
    logic [FP_W-1:0] frac_eff;

    // path switch detector: any change restarts the divider cleanly
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= 1'b0;
            sel_q  <= 2'd0;
        end else begin
            sync_q <= sync_mode_i;
            sel_q  <= src_sel_i;
        end
    end

    assign restart  = (sync_q != sync_mode_i) || (sel_q != src_sel_i);
    assign frac_eff = sync_mode_i ? '0 : frac_i;

    baud_src_sel #(
        .PRESC (PRESC)
    ) src_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_i      (src_sel_i),
        .ext_clk_i  (ext_clk_i),
        .src_en_o   (src_en),
        .ext_lvl_o  (ext_lvl),
        .ext_rise_o (ext_rise)
    );

    baud_frac_div #(
        .CD_W (CD_W),
        .FP_W (FP_W)
    ) div_u (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .src_en_i  (src_en),
        .cd_i      (div_i),
        .fp_i      (frac_eff),
        .pulse_o   (div_pulse),
        .running_o (running),
        .cnt_o     (cnt),
        .cd_o      (cd_live)
    );

    baud_out_stage #(
        .CD_W (CD_W)
    ) out_u (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .restart_i   (restart),
        .sync_i      (sync_mode_i),
        .sel_i       (src_sel_i),
        .os8_i       (os8_i),
        .div_pulse_i (div_pulse),
        .running_i   (running),
        .cnt_i       (cnt),
        .cd_i        (cd_live),
        .ext_rise_i  (ext_rise),
        .ext_lvl_i   (ext_lvl),
        .samp_en_o   (samp_en_o),
        .baud_tick_o (baud_tick_o),
        .clk_pin_o   (clk_pin_o)
    );

endmodule

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  sel;
    logic [15:0] cd;
    logic [2:0]  fp;
    logic        over;
    logic        sync;
    logic        ext;
    logic        samp, baud, pin;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    frac_baud_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_sel_i   (sel),
        .div_i       (cd),
        .frac_i      (fp),
        .os8_i       (over),
        .sync_mode_i (sync),
        .ext_clk_i   (ext),
        .samp_en_o   (samp),
        .baud_tick_o (baud),
        .clk_pin_o   (pin)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] cd;
        logic [2:0]  fp;
        logic        over;
        logic        sync;
        logic [15:0] sum8;
        logic [15:0] baud;
    } vec_t;

    // sel 1 rows exercise the prescaled source of R1 (PRESC = 8)
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd5, 3'd0, 1'b1, 1'b0, 16'd40,  16'd40},
        '{2'd0, 16'd3, 3'd3, 1'b0, 1'b0, 16'd27,  16'd54},
        '{2'd1, 16'd2, 3'd0, 1'b1, 1'b0, 16'd128, 16'd128},
        '{2'd0, 16'd4, 3'd4, 1'b1, 1'b0, 16'd36,  16'd36},
        '{2'd0, 16'd7, 3'd5, 1'b0, 1'b1, 16'd56,  16'd7},
        '{2'd1, 16'd3, 3'd0, 1'b0, 1'b1, 16'd192, 16'd24},
        '{2'd0, 16'd1, 3'd7, 1'b1, 1'b0, 16'd15,  16'd15}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1.25;
        end
    endtask

    task automatic next_samp(output int n);
        n = 0;
        do begin
            step(1);
            n++;
        end while (!samp && n < 5000);
    endtask

    task automatic next_baud(output int n);
        n = 0;
        do begin
            step(1);
            n++;
        end while (!baud && n < 5000);
    endtask

    task automatic count_pulses(input int cycles, output int ns, output int nb);
        ns = 0;
        nb = 0;
        for (int c = 0; c < cycles; c++) begin
            step(1);
            if (samp) ns++;
            if (baud) nb++;
        end
    endtask

    initial begin
        int n, sum, lo, hi, m, ns, nb, hcnt, ticks;
        string rq;
        rst_n = 1'b0;
        sel = 2'd0; cd = 16'd5; fp = 3'd0; over = 1'b1; sync = 1'b0; ext = 1'b0;
        step(3);
        check(!samp && !baud && !pin, "R11", "outputs in reset",
              {29'd0, samp, baud, pin}, 0);
        rst_n = 1'b1;
        step(2);

        // table walk
        for (int i = 0; i < NV; i++) begin
            sel = VECS[i].sel; cd = VECS[i].cd; fp = VECS[i].fp;
            over = VECS[i].over; sync = VECS[i].sync;
            m  = (VECS[i].sel == 2'd1) ? 8 : 1;
            lo = int'(VECS[i].cd) * m;
            hi = (int'(VECS[i].cd) + ((VECS[i].fp != 0 && !VECS[i].sync) ? 1 : 0)) * m;
            rq = VECS[i].sync ? "R5" : ((VECS[i].fp != 0) ? "R3" : "R2");
            next_samp(n);
            next_samp(n);
            sum = 0;
            for (int k = 0; k < 8; k++) begin
                next_samp(n);
                sum += n;
                check(n >= lo && n <= hi, rq, "sample interval", n, lo);
            end
            check(sum == int'(VECS[i].sum8), rq, "eight-period total", sum,
                  int'(VECS[i].sum8));
            next_baud(n);
            next_baud(n);
            check(n == int'(VECS[i].baud), VECS[i].sync ? "R5" : "R4",
                  "baud interval", n, int'(VECS[i].baud));
            if (!VECS[i].sync)
                check(pin == 1'b0, "R9", "pin low in async", int'(pin), 0);
        end

        // R6: divisor change applies at reload
        sel = 2'd0; sync = 1'b0; over = 1'b1; fp = 3'd0; cd = 16'd10;
        next_samp(n);
        next_samp(n);
        step(3);
        cd = 16'd4;
        next_samp(n);
        check(n == 7, "R6", "current period kept", n, 7);
        next_samp(n);
        check(n == 4, "R6", "new divisor period", n, 4);

        // R6: zero divisor stops pulses
        cd = 16'd0;
        step(10);
        count_pulses(200, ns, nb);
        check(ns == 0 && nb == 0, "R6", "pulses with zero divisor", ns + nb, 0);

        // R1: reserved source code 2
        sel = 2'd2; cd = 16'd5;
        step(5);
        count_pulses(200, ns, nb);
        check(ns == 0 && nb == 0, "R1", "pulses with reserved source", ns + nb, 0);

        // R8: half-cycle pin duty, odd then even divisor
        for (int d = 5; d <= 6; d++) begin
            sel = 2'd0; sync = 1'b1; cd = 16'(d);
            step(30);
            hcnt = 0;
            for (int c = 0; c < d; c++) begin
                @(posedge clk); #1.25;
                if (pin) hcnt++;
                @(negedge clk); #1.25;
                if (pin) hcnt++;
            end
            check(hcnt == d, "R8", "pin high half-cycles", hcnt, d);
        end

        // R9: prescaled source pin, divisor 3 -> high 8 of 24 cycles
        sel = 2'd1; sync = 1'b1; cd = 16'd3;
        step(60);
        hcnt = 0;
        for (int c = 0; c < 24; c++) begin
            step(1);
            if (pin) hcnt++;
        end
        check(hcnt == 8, "R9", "prescaled pin high cycles", hcnt, 8);

        // R7: external clock direct in sync mode, divisor ignored
        ext = 1'b0; sel = 2'd3; sync = 1'b1; cd = 16'd0;
        step(10);
        ticks = 0;
        ns = 0;
        for (int k = 0; k < 5; k++) begin
            ext = 1'b1;
            for (int c = 0; c < 10; c++) begin
                step(1);
                if (baud) ticks++;
                if (samp) ns++;
                if (c == 6) check(pin == 1'b1, "R7", "pin follows ext high", int'(pin), 1);
            end
            ext = 1'b0;
            for (int c = 0; c < 10; c++) begin
                step(1);
                if (baud) ticks++;
                if (samp) ns++;
                if (c == 6) check(pin == 1'b0, "R7", "pin follows ext low", int'(pin), 0);
            end
        end
        check(ticks == 5, "R7", "ticks per ext edge", ticks, 5);
        check(ns == 5, "R7", "samples per ext edge", ns, 5);

        // R10: switch sync -> async restarts cleanly
        sel = 2'd0; sync = 1'b1; cd = 16'd6; fp = 3'd0; over = 1'b1;
        step(30);
        sync = 1'b0;
        next_samp(n);
        check(n == 8, "R10", "first sample after switch", n, 8);
        check(pin == 1'b0, "R10", "pin low after switch", int'(pin), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule